// File: doc/BRIEF.md
# Wait-State Peripheral Bus Bridge

This block sits between a fast system-side requester (processor or DMA engine) and a slow register bus that serves peripheral control registers. Each request is carried onto the register bus as one transaction with two timed phases: an address-setup phase and a data phase. The length of each phase comes from a small wait-control register. The bridge also decides how long the requester must wait. Accesses that fall in the fixed register window always hold the requester until the bus transaction ends. In the remaining (programmable) window, reads hold the requester in the same way, but writes are posted: the requester is released at once and the transaction finishes in the background.

The requester keeps `req_valid` and its fields steady until it sees `req_ready` high at a rising clock edge. That edge completes the handshake. Read data is valid on `rsp_rdata` in the same cycle. A processor request (`req_master` = 1) spends one more cycle in completion than the same request from DMA (`req_master` = 0). Only one bus transaction, whether posted or blocking, is in flight at any time. Its address, data and direction are held in the bridge until the transaction ends.

Top module: `pbus_wait_bridge`

## Requirements
- R1: A request whose address lies in the fixed window (bits [AW-1:FIX_LOG2] equal to the same bits of FIX_BASE) gets `req_ready`, for both reads and writes, exactly L = S + D + 3 + C cycles after it is first presented to an idle bridge. S is the setup field, D is the data field, and C is 1 for the processor and 0 for DMA.
- R2: A read in the programmable window is held not-ready for the same L cycles as a fixed-window access.
- R3: A write in the programmable window presented to an idle bridge gets `req_ready` in the same cycle. `busy` is then high from the next cycle until the posted transaction ends.
- R4: A request presented while an earlier transaction is still in flight is held not-ready until the bridge has returned to idle. A write presented the cycle after a posted write therefore waits L cycles. A read presented the cycle after a posted write waits 2L cycles.
- R5: Each transaction begins with S + 1 cycles in which `pb_sel` is high, `pb_strobe` is low, and `pb_addr`, `pb_write` and `pb_wdata` carry the request.
- R6: The data phase follows with D + 1 cycles in which `pb_sel` and `pb_strobe` are both high.
- R7: The completion phase lasts one cycle for DMA and two cycles for the processor. For the same wait settings, the processor's access is one cycle longer than DMA's.
- R8: The wait-control register holds the setup count in bits [1:0] and the data count in bits [3:2]. It is written when `cfg_we` is high at a clock edge and resets to zero. Both fields are sampled when a request is accepted, so a write to the register during a transaction does not change that transaction's phase lengths.
- R9: For a read, `rsp_rdata` carries the value of `pb_rdata` from the last data-phase cycle while `req_ready` is high.
- R10: After reset, `pb_sel`, `pb_strobe` and `busy` are low, and `req_ready` is low while no request is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present, held until ready |
| req_addr | input | AW | Register address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| req_master | input | 1 | 1 = processor, 0 = DMA |
| req_ready | output | 1 | Handshake completes at this edge |
| rsp_rdata | output | DW | Read data, valid with ready |
| cfg_we | input | 1 | Wait-control register write enable |
| cfg_wdata | input | 2*WAIT_W | Wait-control value: [1:0] setup, [3:2] data |
| busy | output | 1 | Posted write still outstanding |
| pb_sel | output | 1 | Register-bus transaction active |
| pb_strobe | output | 1 | Data phase strobe |
| pb_addr | output | AW | Register-bus address |
| pb_write | output | 1 | Register-bus direction |
| pb_wdata | output | DW | Register-bus write data |
| pb_rdata | input | DW | Register-bus read data |

## Verification
Every result is due at a fixed number of cycles that follows from the wait fields and the master type:

| Request | `req_ready` due | 
|---|---|
| Blocking access to an idle bridge | L cycles after it is presented |
| Posted write | the cycle it is presented |
| Write presented behind a posted write | L cycles later |
| Read presented behind a posted write | 2L cycles later |

The bench presents each request just after a falling edge. It re-samples `req_ready` shortly after each following falling edge and counts those samples. The count is compared with the expected figure, so any early or late cycle counts as a failure. A free-running monitor counts the setup and strobe cycles at rising edges, and the bench compares the difference across each blocking access with S + 1 and D + 1. The sweep covers all sixteen wait settings, both master types, and all four combinations of window and direction.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
   localparam int PBW_WAIT_W = 2;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_DATA  = 2'd2,
      PH_DONE  = 2'd3
   } pbw_phase_e;

   typedef struct packed {
      logic [PBW_WAIT_W-1:0] data_w;
      logic [PBW_WAIT_W-1:0] setup_w;
   } pbw_wait_t;
endpackage

// File: rtl/pbw_wait_cfg.sv
module pbw_wait_cfg
   import pbw_pkg::*;
#(
   parameter int WAIT_W = PBW_WAIT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [2*WAIT_W-1:0] wdata,
   output pbw_wait_t         cfg
);
   initial begin
      assert (WAIT_W == PBW_WAIT_W)
         else $error("wait field width must match package");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  cfg <= '0;
      else if (we) cfg <= pbw_wait_t'(wdata);
   end
endmodule

// File: rtl/pbw_window_dec.sv
module pbw_window_dec #(
   parameter int            AW       = 8,
   parameter int            FIX_LOG2 = 4,
   parameter logic [AW-1:0] FIX_BASE = '0,
   parameter bit            POST_EN  = 1'b1
) (
   input  logic [AW-FIX_LOG2-1:0] tag,
   input  logic                   is_write,
   output logic                   in_fixed,
   output logic                   posted
);
   localparam logic [AW-FIX_LOG2-1:0] BASE_TAG = FIX_BASE[AW-1:FIX_LOG2];

   initial begin
      assert (FIX_LOG2 > 0 && FIX_LOG2 < AW)
         else $error("fixed window size must be inside the address space");
   end

   assign in_fixed = (tag == BASE_TAG);

   generate
      if (POST_EN) begin : g_post
         assign posted = is_write && !in_fixed;
      end else begin : g_block
         assign posted = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pbw_seq.sv
module pbw_seq
   import pbw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  pbw_wait_t  cfg,
   input  logic       cpu,
   output pbw_phase_e phase,
   output logic       data_last,
   output logic       done_last
);
   logic [PBW_WAIT_W-1:0] cnt;
   logic [PBW_WAIT_W-1:0] data_q;
   logic                  cpu_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         cnt    <= '0;
         data_q <= '0;
         cpu_q  <= 1'b0;
      end else begin
         unique case (phase)
            PH_IDLE: if (start) begin
               phase  <= PH_SETUP;
               cnt    <= cfg.setup_w;
               data_q <= cfg.data_w;
               cpu_q  <= cpu;
            end
            PH_SETUP: if (cnt == '0) begin
               phase <= PH_DATA;
               cnt   <= data_q;
            end else begin
               cnt <= cnt - 1'b1;
            end
            PH_DATA: if (cnt == '0) begin
               phase <= PH_DONE;
               cnt   <= cpu_q ? PBW_WAIT_W'(1) : '0;
            end else begin
               cnt <= cnt - 1'b1;
            end
            PH_DONE: if (cnt == '0) begin
               phase <= PH_IDLE;
            end else begin
               cnt <= cnt - 1'b1;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign data_last = (phase == PH_DATA) && (cnt == '0);
   assign done_last = (phase == PH_DONE) && (cnt == '0);

   // R5: the data phase is only ever entered from setup or itself
   a_r5_data_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA) |-> ($past(phase) == PH_SETUP || $past(phase) == PH_DATA));
   // R6: completion is only reached from the data phase
   a_r6_done_after_data: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DONE && $past(phase) != PH_DONE) |-> $past(phase) == PH_DATA);
endmodule

// File: rtl/pbus_wait_bridge.sv
module pbus_wait_bridge
   import pbw_pkg::*;
#(
   parameter int            AW       = 8,
   parameter int            DW       = 16,
   parameter int            WAIT_W   = 2,
   parameter int            FIX_LOG2 = 4,
   parameter logic [AW-1:0] FIX_BASE = '0,
   parameter bit            POST_EN  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [AW-1:0]       req_addr,
   input  logic                req_write,
   input  logic [DW-1:0]       req_wdata,
   input  logic                req_master,
   output logic                req_ready,
   output logic [DW-1:0]       rsp_rdata,
   input  logic                cfg_we,
   input  logic [2*WAIT_W-1:0] cfg_wdata,
   output logic                busy,
   output logic                pb_sel,
   output logic                pb_strobe,
   output logic [AW-1:0]       pb_addr,
   output logic                pb_write,
   output logic [DW-1:0]       pb_wdata,
   input  logic [DW-1:0]       pb_rdata
);
   initial begin
      assert (DW > 0 && AW > 1) else $error("bad bus widths");
   end

   pbw_wait_t  cfg;
   pbw_phase_e phase;
   logic       data_last, done_last;
   logic       in_fixed, posted_req, accept;
   logic       lat_posted;
   logic [DW-1:0] rdata_q;

   pbw_wait_cfg #(.WAIT_W(WAIT_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg));

   pbw_window_dec #(.AW(AW), .FIX_LOG2(FIX_LOG2), .FIX_BASE(FIX_BASE), .POST_EN(POST_EN)) u_dec (
      .tag(req_addr[AW-1:FIX_LOG2]), .is_write(req_write),
      .in_fixed(in_fixed), .posted(posted_req));

   assign accept = (phase == PH_IDLE) && req_valid;

   pbw_seq u_seq (
      .clk(clk), .rst_n(rst_n), .start(accept), .cfg(cfg), .cpu(req_master),
      .phase(phase), .data_last(data_last), .done_last(done_last));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pb_addr    <= '0;
         pb_write   <= 1'b0;
         pb_wdata   <= '0;
         lat_posted <= 1'b0;
         rdata_q    <= '0;
      end else begin
         if (accept) begin
            pb_addr    <= req_addr;
            pb_write   <= req_write;
            pb_wdata   <= req_wdata;
            lat_posted <= posted_req;
         end
         if (data_last) rdata_q <= pb_rdata;
      end
   end

   assign pb_sel    = (phase == PH_SETUP) || (phase == PH_DATA);
   assign pb_strobe = (phase == PH_DATA);
   assign busy      = lat_posted && (phase != PH_IDLE);
   assign rsp_rdata = rdata_q;
   assign req_ready = req_valid &&
                      ((accept && posted_req) || (done_last && !lat_posted));

   // R3: a posted handshake leaves the bridge busy on the next cycle
   a_r3_posted_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && posted_req) |=> busy);
   // R4: no handshake while a posted write is still outstanding
   a_r4_no_ready_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !req_ready);
   // R1: a blocking handshake only after the register bus is released
   a_r1_block_after_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !posted_req) |-> !pb_sel);
   // R5: the address is held for the whole transaction
   a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      pb_sel |=> (!pb_sel || $stable(pb_addr)));
   // R5: a transaction always opens with a setup cycle
   a_r5_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pb_sel) |-> !pb_strobe);
endmodule

// File: tb/pbus_wait_bridge_tb.sv
`timescale 1ns/100ps
module pbus_wait_bridge_tb;
   localparam int AW = 8;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_write = 1'b0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_master = 1'b0;
   logic          req_ready;
   logic [DW-1:0] rsp_rdata;
   logic          cfg_we = 1'b0;
   logic [3:0]    cfg_wdata = '0;
   logic          busy, pb_sel, pb_strobe, pb_write;
   logic [AW-1:0] pb_addr;
   logic [DW-1:0] pb_wdata;
   logic [DW-1:0] pb_rdata;
   logic [DW-1:0] mem [16];

   int tests = 0;
   int fails = 0;
   int setup_cyc = 0;
   int data_cyc = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pbus_wait_bridge #(.AW(AW), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .req_wdata(req_wdata), .req_master(req_master),
      .req_ready(req_ready), .rsp_rdata(rsp_rdata), .cfg_we(cfg_we),
      .cfg_wdata(cfg_wdata), .busy(busy), .pb_sel(pb_sel), .pb_strobe(pb_strobe),
      .pb_addr(pb_addr), .pb_write(pb_write), .pb_wdata(pb_wdata), .pb_rdata(pb_rdata));

   assign pb_rdata = mem[pb_addr[3:0]];

   always @(posedge clk) begin
      if (pb_strobe && pb_write) mem[pb_addr[3:0]] <= pb_wdata;
      if (pb_sel && !pb_strobe) setup_cyc <= setup_cyc + 1;
      if (pb_strobe) data_cyc <= data_cyc + 1;
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         fails = fails + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      tests = tests + 1;
      if (act != exp) begin
         fails = fails + 1;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic set_cfg(input int s, input int d);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = 4'((d << 2) | s);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // presents a request, returns cycles waited and read data
   task automatic access(input logic [AW-1:0] a, input logic wr, input logic [DW-1:0] wd,
                         input logic m, input bit tweak, input int s, input int d,
                         output int lat, output logic [DW-1:0] rd);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd; req_master = m;
      #0.5;
      lat = 0;
      while (!req_ready && lat < 200) begin
         @(negedge clk);
         cfg_we = 1'b0;
         if (tweak && lat == 0) begin
            cfg_we = 1'b1;
            cfg_wdata = 4'(((3 - d) << 2) | (3 - s));
         end
         #0.5;
         lat = lat + 1;
      end
      rd = rsp_rdata;
      @(posedge clk);
      #0.5;
      req_valid = 1'b0;
      cfg_we = 1'b0;
   endtask

   initial begin
      int lat;
      logic [DW-1:0] rd;
      for (int i = 0; i < 16; i++) mem[i] = '0;
      repeat (3) @(posedge clk);
      #0.5;
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk("R10 pb_sel after reset", int'(pb_sel), 0);
      chk("R10 pb_strobe after reset", int'(pb_strobe), 0);
      chk("R10 busy after reset", int'(busy), 0);
      chk("R10 ready idle", int'(req_ready), 0);

      for (int s = 0; s < 4; s++) begin
         for (int d = 0; d < 4; d++) begin
            for (int m = 0; m < 2; m++) begin
               int el;
               int s0, d0;
               logic [DW-1:0] v1, v2, v3;
               el = s + d + 3 + m;
               v1 = DW'(16'h1000 + s * 64 + d * 8 + m);
               v2 = ~v1;
               v3 = v1 ^ 16'h5a5a;
               set_cfg(s, d);

               // R1 fixed write, R5/R6 phase lengths, R7 master cost
               s0 = setup_cyc; d0 = data_cyc;
               access(8'h03, 1'b1, v1, m[0], 1'b0, s, d, lat, rd);
               chk("R1/R7 fixed write latency", lat, el);
               chk("R5 setup cycles fixed write", setup_cyc - s0, s + 1);
               chk("R6 strobe cycles fixed write", data_cyc - d0, d + 1);

               // R1 fixed read with R8 mid-access config change, R9 data
               s0 = setup_cyc; d0 = data_cyc;
               access(8'h03, 1'b0, '0, m[0], 1'b1, s, d, lat, rd);
               chk("R1/R8 fixed read latency", lat, el);
               chk("R9 fixed read data", int'(rd), int'(v1));
               chk("R8 setup cycles unchanged", setup_cyc - s0, s + 1);
               chk("R8 strobe cycles unchanged", data_cyc - d0, d + 1);
               set_cfg(s, d);

               // R3 posted write accepted at once
               access(8'h1a, 1'b1, v2, m[0], 1'b0, s, d, lat, rd);
               chk("R3 posted write latency", lat, 0);
               chk("R3 busy after posted write", int'(busy), 1);
               // R4 write behind posted write
               access(8'h1b, 1'b1, v3, m[0], 1'b0, s, d, lat, rd);
               chk("R4 write stall behind posted", lat, el);
               // R4/R2 read behind posted write
               access(8'h1a, 1'b0, '0, m[0], 1'b0, s, d, lat, rd);
               chk("R4/R2 read behind posted", lat, 2 * el);
               chk("R9 programmable read data", int'(rd), int'(v2));
               // R2 read to idle bridge
               access(8'h1b, 1'b0, '0, m[0], 1'b0, s, d, lat, rd);
               chk("R2 programmable read latency", lat, el);
               chk("R9 posted write landed", int'(rd), int'(v3));
               chk("R3 busy clear after read", int'(busy), 0);
            end
         end
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule